// File: doc/BRIEF.md
# Level-Sensitive DMA Request Acceptance and Single-Transfer Sequencer

This block serves one DMA channel whose peripheral signals its need for service by pulling an active-low request line low and keeping it there. Once software enables the channel (a strobe that marks the end of the enabling register write, along with a transfer count), the block samples the resynchronised line on every clock edge. A low sample latches an internal pending-request flag. That flag survives the line going high again. A latched request raises a bus request. On the first cycle in which the bus grant is seen during arbitration, the block activates: it clears the pending flag and runs one read cycle from the source, then one write cycle to the destination. After that it releases the bus.

From activation until the write cycle completes, the request line is ignored. After the write completes, sampling resumes on the next edge, so a line held low produces back-to-back single transfers. Each completed write decrements the transfer count. When the count reaches zero, the channel disables itself and emits a one-cycle done pulse. A disable strobe discards any request that is pending but not yet activated.

Top module: `dreq_level_dma`

## Requirements
- R1: While the channel is disabled the pending flag `req_held` stays 0. The earliest edge that can set it is the edge after the one that registers `en_wr`.
- R2: `dreq_n` is active low and passes through a two-flop synchronizer. A low level present at a rising edge sets `req_held` on the third edge after it, provided acceptance is open. `req_held` then stays 1 after `dreq_n` returns high, until it is cleared by activation or by disable.
- R3: With `req_held` set and the bus idle, `bus_req` rises on the next edge. `activate` is 1 in a cycle where arbitration is under way and `bus_grant` is 1. On that edge `req_held` clears and `rd_cyc` becomes 1.
- R4: From the activation cycle until the edge on which the write completes, a low `dreq_n` does not set `req_held`.
- R5: `rd_cyc` stays 1 up to and including the cycle in which `rd_done` is 1, and `wr_cyc` follows on the next edge. `wr_cyc` stays 1 up to the cycle in which `wr_done` is 1. After that `bus_req` is 0 and `bus_idle` is 1.
- R6: Acceptance resumes after the write completes: a still-low line sets `req_held` one edge after completion. With `dreq_n` kept low and `bus_grant` kept high, successive read starts are (read cycles + write cycles + 3) clock cycles apart.
- R7: A read cycle starts at least 2 cycles after the request is sampled. With `bus_grant` already high and an idle bus, `rd_cyc` is 1 after the fifth rising edge following `dreq_n` going low.
- R8: `en_wr` loads the count, and each completed write decrements it. The write that brings it to zero makes `xfer_done` 1 for exactly one cycle and `chan_on` 0 at the same time. No further request is latched after that.
- R9: If `dis_wr` is 1 while a request is pending or under arbitration, `req_held`, `bus_req` and `chan_on` are 0 after that edge, and no read cycle starts.
- R10: `en_wr` is ignored when `xfer_count` is 0 or when the channel is already on, so the running count is kept. `dis_wr` wins over `en_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dreq_n | input | 1 | Asynchronous active-low level request from the peripheral |
| en_wr | input | 1 | One-cycle strobe: enabling register write has ended |
| dis_wr | input | 1 | One-cycle strobe: disable the channel |
| xfer_count | input | CNT_W | Number of transfers, loaded by `en_wr` |
| bus_grant | input | 1 | Bus granted to this channel |
| rd_done | input | 1 | Current read cycle completes this cycle |
| wr_done | input | 1 | Current write cycle completes this cycle |
| req_held | output | 1 | Latched pending request |
| activate | output | 1 | Activation (pending request cleared) this cycle |
| bus_req | output | 1 | Bus request to the arbiter |
| rd_cyc | output | 1 | DMA read cycle from the source in progress |
| wr_cyc | output | 1 | DMA write cycle to the destination in progress |
| bus_idle | output | 1 | Channel holds no bus activity |
| xfer_done | output | 1 | One-cycle pulse when the count reaches zero |
| chan_on | output | 1 | Channel enabled |

## Verification
The bench targets three cases:
- A request that is already low when the channel is enabled. A design that samples too early latches it on the enabling edge; one that waits too long adds a cycle.
- A line that is held low through the read and write cycles. A design with a leaky blanking window re-latches during the transfer. A design that reopens late stretches the back-to-back period, which the bench sweeps over read and write latencies and counts.
- Disable during arbitration, a zero count, and a second enable while running. Getting these wrong shows as a stray read cycle, a channel that never ends, or the wrong number of transfers before the done pulse.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ARB   = 2'd1,
        PH_READ  = 2'd2,
        PH_WRITE = 2'd3
    } dma_phase_e;

    typedef struct packed {
        logic breq;
        logic rd;
        logic wr;
        logic idle;
    } bus_ctl_t;

    function automatic bus_ctl_t decode_phase(dma_phase_e p);
        bus_ctl_t c;
        c.breq = (p != PH_IDLE);
        c.rd   = (p == PH_READ);
        c.wr   = (p == PH_WRITE);
        c.idle = (p == PH_IDLE);
        return c;
    endfunction

    function automatic logic accept_window(dma_phase_e p);
        return (p == PH_IDLE) || (p == PH_ARB);
    endfunction

endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic lvl_low
);
    logic [STAGES-1:0] ff_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) ff_q[0] <= 1'b1;
                else     ff_q[0] <= pin_n;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) ff_q[i] <= 1'b1;
                else     ff_q[i] <= ff_q[i-1];
            end
        end
    end

    assign lvl_low = ~ff_q[STAGES-1];
endmodule

// File: rtl/dreq_hold.sv
module dreq_hold (
    input  logic clk,
    input  logic rst,
    input  logic req_low,
    input  logic open_i,
    input  logic clr_i,
    output logic held_o
);
    logic held_q;

    always_ff @(posedge clk) begin
        if (rst)                     held_q <= 1'b0;
        else if (clr_i)              held_q <= 1'b0;
        else if (open_i && req_low)  held_q <= 1'b1;
    end

    assign held_o = held_q;

    // R2
    held_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (held_q && !clr_i) |=> held_q);
endmodule

// File: rtl/dreq_seq.sv
module dreq_seq
    import dreq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_wr,
    input  logic             dis_wr,
    input  logic [CNT_W-1:0] xfer_count,
    input  logic             held_i,
    input  logic             bus_grant,
    input  logic             rd_done,
    input  logic             wr_done,
    output dma_phase_e       phase_o,
    output logic             activate_o,
    output logic             chan_on_o,
    output logic             done_o,
    output bus_ctl_t         ctl_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

    dma_phase_e       phase_q, phase_d;
    logic             on_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    logic             wr_fin;

    assign activate_o = (phase_q == PH_ARB) && bus_grant && on_q && !dis_wr;
    assign wr_fin     = (phase_q == PH_WRITE) && wr_done;

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:  if (held_i && on_q && !dis_wr) phase_d = PH_ARB;
            PH_ARB:   if (dis_wr) phase_d = PH_IDLE;
                      else if (activate_o) phase_d = PH_READ;
            PH_READ:  if (rd_done) phase_d = PH_WRITE;
            PH_WRITE: if (wr_done) phase_d = PH_IDLE;
            default:  phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            on_q    <= 1'b0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            done_q  <= wr_fin && (cnt_q == LAST);
            if (dis_wr) begin
                on_q <= 1'b0;
            end else if (en_wr && !on_q && (xfer_count != '0)) begin
                on_q  <= 1'b1;
                cnt_q <= xfer_count;
            end else if (wr_fin) begin
                cnt_q <= cnt_q - LAST;
                if (cnt_q == LAST) on_q <= 1'b0;
            end
        end
    end

    assign phase_o   = phase_q;
    assign chan_on_o = on_q;
    assign done_o    = done_q;
    assign ctl_o     = decode_phase(phase_q);

    // R3
    act_starts_read_chk: assert property (@(posedge clk) disable iff (rst)
        activate_o |=> (ctl_o.rd && !held_i));
    // R4
    blank_in_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_o.rd || ctl_o.wr) |-> !held_i);
    // R5
    read_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_o.rd && !rd_done) |=> ctl_o.rd);
    // R8
    done_off_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !on_q);
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    // R9
    dis_drop_chk: assert property (@(posedge clk) disable iff (rst)
        ((phase_q == PH_ARB) && dis_wr) |=> (!ctl_o.breq && !on_q));
endmodule

// File: rtl/dreq_level_dma.sv
module dreq_level_dma
    import dreq_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dreq_n,
    input  logic             en_wr,
    input  logic             dis_wr,
    input  logic [CNT_W-1:0] xfer_count,
    input  logic             bus_grant,
    input  logic             rd_done,
    input  logic             wr_done,
    output logic             req_held,
    output logic             activate,
    output logic             bus_req,
    output logic             rd_cyc,
    output logic             wr_cyc,
    output logic             bus_idle,
    output logic             xfer_done,
    output logic             chan_on
);
    logic       lvl_low;
    logic       held;
    logic       act;
    logic       on;
    logic       accept_open;
    dma_phase_e phase;
    bus_ctl_t   ctl;

    dreq_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pin_n   (dreq_n),
        .lvl_low (lvl_low)
    );

    assign accept_open = on && accept_window(phase) && !act;

    dreq_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .req_low (lvl_low),
        .open_i  (accept_open),
        .clr_i   (act || dis_wr),
        .held_o  (held)
    );

    dreq_seq #(.CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .en_wr      (en_wr),
        .dis_wr     (dis_wr),
        .xfer_count (xfer_count),
        .held_i     (held),
        .bus_grant  (bus_grant),
        .rd_done    (rd_done),
        .wr_done    (wr_done),
        .phase_o    (phase),
        .activate_o (act),
        .chan_on_o  (on),
        .done_o     (xfer_done),
        .ctl_o      (ctl)
    );

    assign req_held = held;
    assign activate = act;
    assign chan_on  = on;
    assign bus_req  = ctl.breq;
    assign rd_cyc   = ctl.rd;
    assign wr_cyc   = ctl.wr;
    assign bus_idle = ctl.idle;

    // R1
    off_no_held_chk: assert property (@(posedge clk) disable iff (rst)
        !chan_on |-> !req_held);
endmodule

// File: tb/tb_dreq_level_dma.sv
module tb_dreq_level_dma;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             dreq_n = 1'b1;
    logic             en_wr = 1'b0;
    logic             dis_wr = 1'b0;
    logic [CNT_W-1:0] xfer_count = '0;
    logic             bus_grant = 1'b0;
    logic             rd_done = 1'b0;
    logic             wr_done = 1'b0;
    logic req_held, activate, bus_req, rd_cyc, wr_cyc, bus_idle, xfer_done, chan_on;

    int checks = 0;
    int fails  = 0;
    int rl = 3;
    int wl = 2;
    int rdc = 0;
    int wrc = 0;
    bit finished = 1'b0;

    dreq_level_dma #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .dreq_n(dreq_n), .en_wr(en_wr), .dis_wr(dis_wr),
        .xfer_count(xfer_count), .bus_grant(bus_grant), .rd_done(rd_done),
        .wr_done(wr_done), .req_held(req_held), .activate(activate),
        .bus_req(bus_req), .rd_cyc(rd_cyc), .wr_cyc(wr_cyc), .bus_idle(bus_idle),
        .xfer_done(xfer_done), .chan_on(chan_on)
    );

    always #10 clk = ~clk;

    // bus slave model: completes a read after rl extra cycles, a write after wl
    always @(negedge clk) begin
        if (rd_cyc) begin rd_done = (rdc == rl); rdc++; end
        else begin rd_done = 1'b0; rdc = 0; end
        if (wr_cyc) begin wr_done = (wrc == wl); wrc++; end
        else begin wr_done = 1'b0; wrc = 0; end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic enable(input int cnt);
        en_wr = 1'b1; xfer_count = CNT_W'(cnt);
        step(1);
        en_wr = 1'b0;
    endtask

    task automatic run_to_done(output int starts, output int seen);
        bit prev = 1'b0;
        starts = 0; seen = 0;
        for (int i = 0; i < 600 && seen == 0; i++) begin
            if (rd_cyc && !prev) starts++;
            prev = rd_cyc;
            if (xfer_done) seen = 1;
            else step(1);
        end
    endtask

    task automatic sweep(input int cnt, input int r, input int w);
        int starts = 0, ndone = 0, last = 0, cyc = 0;
        bit prev = 1'b0;
        rl = r; wl = w;
        dreq_n = 1'b0; bus_grant = 1'b1;
        step(3);
        enable(cnt);
        for (int i = 0; i < 400; i++) begin
            cyc++;
            if (rd_cyc && !prev) begin
                // R6 back-to-back period
                if (starts > 0) chk(cyc - last == r + w + 5, "R6 period", cyc - last, r + w + 5);
                last = cyc;
                starts++;
            end
            prev = rd_cyc;
            if (xfer_done) ndone++;
            step(1);
        end
        // R8 transfer count and single done
        chk(starts == cnt, "R8 transfers", starts, cnt);
        chk(ndone == 1, "R8 done pulses", ndone, 1);
        chk(!chan_on && !req_held, "R8 off after end", {chan_on, req_held}, 0);
        dreq_n = 1'b1;
        step(4);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n, s, d;
        step(3);
        rst = 1'b0;
        step(1);
        chk(!req_held && !bus_req && !rd_cyc && !wr_cyc && bus_idle && !chan_on && !xfer_done,
            "reset state", {req_held, bus_req, rd_cyc, wr_cyc, bus_idle, chan_on}, 2);

        // R1: disabled channel ignores a low line
        dreq_n = 1'b0;
        step(5);
        chk(!req_held && !bus_req, "R1 disabled", req_held, 0);

        // R1: first sample on the edge after the enabling edge
        en_wr = 1'b1; xfer_count = 8'd3;
        step(1);
        en_wr = 1'b0;
        chk(chan_on && !req_held, "R1 not on enable edge", req_held, 0);
        step(1);
        chk(req_held, "R1 first sample edge", req_held, 1);

        // R3 bus request, R2 flag sticks after line goes high
        step(1);
        dreq_n = 1'b1;
        chk(bus_req && req_held, "R3 bus_req rises", bus_req, 1);
        step(3);
        chk(req_held && !rd_cyc, "R2 held sticky", req_held, 1);

        // R3 activation on grant
        bus_grant = 1'b1;
        #1;
        chk(activate, "R3 activate on grant", activate, 1);
        step(1);
        chk(!req_held && rd_cyc && !activate, "R3 cleared, read", {req_held, rd_cyc}, 1);

        // R4 blanking, R5 read/write phases
        dreq_n = 1'b0;
        n = 0;
        while (rd_cyc && n < 50) begin
            chk(!req_held, "R4 blank in read", req_held, 0);
            n++; step(1);
        end
        chk(n == rl + 1, "R5 read length", n, rl + 1);
        chk(wr_cyc, "R5 write follows", wr_cyc, 1);
        n = 0;
        while (wr_cyc && n < 50) begin
            chk(!req_held, "R4 blank in write", req_held, 0);
            n++; step(1);
        end
        chk(n == wl + 1, "R5 write length", n, wl + 1);
        chk(bus_idle && !bus_req && !req_held, "R5 bus released", bus_req, 0);
        step(1);
        chk(req_held, "R6 acceptance resumes", req_held, 1);

        // R8 two remaining transfers, then done
        run_to_done(s, d);
        chk(d == 1 && s == 2, "R8 remaining transfers", s, 2);
        chk(!chan_on, "R8 chan off with done", chan_on, 0);
        step(1);
        chk(!xfer_done, "R8 done one cycle", xfer_done, 0);
        step(4);
        chk(!req_held && !bus_req, "R8 no request after end", req_held, 0);

        // R9 disable during arbitration
        bus_grant = 1'b0;
        enable(2);
        step(2);
        chk(bus_req && req_held, "R9 setup arb", bus_req, 1);
        dis_wr = 1'b1;
        step(1);
        dis_wr = 1'b0;
        chk(!req_held && !bus_req && !chan_on, "R9 dropped", {req_held, bus_req, chan_on}, 0);
        bus_grant = 1'b1;
        n = 0;
        for (int i = 0; i < 6; i++) begin
            if (rd_cyc || req_held) n++;
            step(1);
        end
        chk(n == 0, "R9 no read", n, 0);

        // R10 zero count ignored
        enable(0);
        step(3);
        chk(!chan_on && !req_held, "R10 zero count", chan_on, 0);

        // R10 re-enable while on keeps count
        en_wr = 1'b1; xfer_count = 8'd1;
        step(1);
        xfer_count = 8'd5;
        step(1);
        en_wr = 1'b0;
        run_to_done(s, d);
        chk(d == 1 && s == 1, "R10 second enable ignored", s, 1);
        step(2);

        // R10 disable beats enable
        dreq_n = 1'b1;
        en_wr = 1'b1; dis_wr = 1'b1; xfer_count = 8'd2;
        step(1);
        en_wr = 1'b0; dis_wr = 1'b0;
        chk(!chan_on, "R10 disable priority", chan_on, 0);

        // R7 request-to-read spacing
        enable(1);
        step(3);
        dreq_n = 1'b0;
        n = 0;
        while (!rd_cyc && n < 30) begin n++; step(1); end
        chk(n == 5 && n >= 2, "R7 spacing", n, 5);
        run_to_done(s, d);
        dreq_n = 1'b1;
        step(4);

        // R6/R8 sweep over count and bus latencies
        for (int c = 1; c <= 4; c++)
            for (int r = 0; r <= 2; r++)
                for (int w = 0; w <= 2; w++)
                    sweep(c, r, w);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule